// File: doc/BRIEF.md
# DTMF Steering Guard-Time Controller

This block is the digital timing stage that follows a DTMF tone classifier. The classifier reports an early flag, high while it sees a valid tone pair, together with the row index (low-group tone) and the column index (high-group tone) of that pair. The controller turns the indices into a 4-bit digit code. It registers the code only after the early flag has stayed high for a programmable tone-present guard time. A delayed steering flag then rises after a short settle interval, and it falls only once the tone has been absent for a programmable tone-absent guard time. Both guard times are counted in ticks from a prescaler that divides the system clock. The prescaler restarts whenever a guard period starts, so every guard has an exact length.

The early flag is qualified before any timing. The qualified flag is the early flag with the letter column removed while letter inhibit is high. The controller has five states. In IDLE it waits for the qualified flag. It moves to PRESENT_WAIT on the first qualified sample. It falls back to IDLE on any unqualified sample. It moves to SETTLE, and loads the code latch, when the present guard completes (directly from IDLE when the guard is a single cycle). SETTLE always moves to HELD when the settle count ends. HELD moves to ABSENT_WAIT on an unqualified sample. ABSENT_WAIT returns to HELD when the tone comes back, which tolerates the dropout. It moves to IDLE when the absent guard completes (directly from HELD when that guard is one cycle). The delayed flag is high in HELD and ABSENT_WAIT.

With a 200 MHz clock the default parameters give 1 ms ticks and 30-tick guards. A tone of 40 ms or more is accepted and one of 20 ms or less is rejected. Pauses behave the same way. The settle delay is 4 µs.

Top module: `dtmf_steer_ctrl`

## Requirements
- R1: During and straight after reset, the code latch holds 0000, the delayed flag is low and the controller is in IDLE.
- R2: Let LP = PRESENT_TICKS × CLKS_PER_TICK. The code latch loads on the clock edge that samples the LP-th consecutive qualified-high value, counted while in IDLE or PRESENT_WAIT. A shorter run of qualified samples leaves the latch unchanged.
- R3: The delayed flag rises exactly SETTLE_CYCLES clock edges after the edge that loads the latch. The latch does not change in that interval.
- R4: Let LA = ABSENT_TICKS × CLKS_PER_TICK. The delayed flag falls on the edge that samples the LA-th consecutive unqualified value after it rose. A shorter dropout leaves the flag high and the latch unchanged.
- R5: While the delayed flag is high, the latch is not reloaded, even if the row or column inputs change. A new digit starts timing only from IDLE.
- R6: The code map works as follows. Row r is 0..3 for the low tones, ascending. Column c is 0..3 for the high tones, ascending. For c < 3 and r < 3, the code is 3r + c + 1 (digits 1..9). Row 3 gives 1011 for '*' (c=0), 1010 for '0' (c=1) and 1100 for '#' (c=2). Column 3 gives the letters: 1101 for A (r=0), 1110 for B (r=1), 1111 for C (r=2) and 0000 for D (r=3).
- R7: While inhibit_letters is high, a column-3 tone counts as no tone. It is never registered, and the latch keeps its previous code.
- R8: While out_enable is low, digit_q reads 0000 and digit_drive is low. The latch is unaffected, and its code shows again on digit_q in the same cycle that out_enable returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| early_flag | input | 1 | Classifier sees a valid tone pair |
| tone_row | input | 2 | Low-group tone index |
| tone_col | input | 2 | High-group tone index |
| inhibit_letters | input | 1 | Ignore column-3 (letter) tones when high |
| out_enable | input | 1 | Enables the digit output |
| digit_q | output | 4 | Latched digit code, zero when disabled |
| digit_drive | output | 1 | Pad drive enable for digit_q |
| steer_delayed | output | 1 | Delayed steering flag |

## Verification
Two things can meet on one clock edge: the end of the absent guard and the return of a tone. The bench ends a dropout one sample short of LA, where the flag must stay high. It also ends one exactly at LA, followed at once by a new tone, where the flag must fall and the new tone must start its count on the next edge. Registration and output-enable changes also meet: out_enable is lowered and raised around the loading edge, and the gated value is compared on every cycle against a behavioural model that counts consecutive samples.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRESENT_WAIT,
        ST_SETTLE,
        ST_HELD,
        ST_ABSENT_WAIT
    } steer_state_t;

    typedef logic [3:0] digit_code_t;

    localparam int ROW_W      = 2;
    localparam int COL_W      = 2;
    localparam int LETTER_COL = 3;

endpackage

// File: rtl/dtmf_code_map.sv
module dtmf_code_map
    import dtmf_steer_pkg::*;
(
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output digit_code_t      code,
    output logic             is_letter
);

    localparam logic [ROW_W-1:0] SYMBOL_ROW = ROW_W'(3);

    always_comb begin
        is_letter = (col == COL_W'(LETTER_COL));
        code      = 4'b0000;
        if (is_letter) begin
            // 1101 upward, the last row wraps to 0000
            code = 4'(4'd13 + {2'b00, row});
        end else if (row != SYMBOL_ROW) begin
            code = 4'({2'b00, row} * 4'd3 + {2'b00, col} + 4'd1);
        end else begin
            unique case (col)
                2'd0:    code = 4'b1011;
                2'd1:    code = 4'b1010;
                default: code = 4'b1100;
            endcase
        end
    end

endmodule

// File: rtl/dtmf_guard_timer.sv
module dtmf_guard_timer #(
    parameter int PRESCALE = 4,
    parameter int LIMIT    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam int TW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [PW-1:0] PRE_LAST  = PW'(PRESCALE - 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(LIMIT - 1);

    logic [PW-1:0] pre_q;
    logic [TW-1:0] tk_q;
    logic          tick;

    assign tick   = (pre_q == PRE_LAST);
    assign expire = run && tick && (tk_q == TICK_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            tk_q  <= '0;
        end else if (!run || expire) begin
            pre_q <= '0;
            tk_q  <= '0;
        end else if (tick) begin
            pre_q <= '0;
            tk_q  <= tk_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R2
    tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (tk_q <= TICK_LAST));

    // R4
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> (pre_q == '0 && tk_q == '0));

endmodule

// File: rtl/dtmf_steer_fsm.sv
module dtmf_steer_fsm
    import dtmf_steer_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         qual,
    input  logic         present_exp,
    input  logic         settle_exp,
    input  logic         absent_exp,
    output steer_state_t state,
    output logic         run_present,
    output logic         run_settle,
    output logic         run_absent,
    output logic         load_code,
    output logic         delayed
);

    steer_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        run_present = 1'b0;
        run_settle  = 1'b0;
        run_absent  = 1'b0;
        load_code   = 1'b0;
        delayed     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                run_present = qual;
                if (qual && present_exp) begin
                    load_code = 1'b1;
                    state_d   = ST_SETTLE;
                end else if (qual) begin
                    state_d = ST_PRESENT_WAIT;
                end
            end
            ST_PRESENT_WAIT: begin
                run_present = qual;
                if (!qual) begin
                    state_d = ST_IDLE;
                end else if (present_exp) begin
                    load_code = 1'b1;
                    state_d   = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                run_settle = 1'b1;
                if (settle_exp) state_d = ST_HELD;
            end
            ST_HELD: begin
                delayed    = 1'b1;
                run_absent = !qual;
                if (!qual && absent_exp) state_d = ST_IDLE;
                else if (!qual)          state_d = ST_ABSENT_WAIT;
            end
            ST_ABSENT_WAIT: begin
                delayed    = 1'b1;
                run_absent = !qual;
                if (qual)            state_d = ST_HELD;
                else if (absent_exp) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state = state_q;

    // R5
    idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRESENT_WAIT) |-> ($past(state_q) inside {ST_IDLE, ST_PRESENT_WAIT}));

endmodule

// File: rtl/dtmf_steer_ctrl.sv
module dtmf_steer_ctrl
    import dtmf_steer_pkg::*;
#(
    parameter int CLKS_PER_TICK = 200000,
    parameter int PRESENT_TICKS = 30,
    parameter int ABSENT_TICKS  = 30,
    parameter int SETTLE_CYCLES = 800
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             early_flag,
    input  logic [ROW_W-1:0] tone_row,
    input  logic [COL_W-1:0] tone_col,
    input  logic             inhibit_letters,
    input  logic             out_enable,
    output logic [3:0]       digit_q,
    output logic             digit_drive,
    output logic             steer_delayed
);

    digit_code_t  mapped_code;
    digit_code_t  latch_q;
    logic         is_letter;
    logic         qual;
    logic         run_present, run_settle, run_absent;
    logic         present_exp, settle_exp, absent_exp;
    logic         load_code;
    steer_state_t state_q;

    dtmf_code_map u_map (
        .row       (tone_row),
        .col       (tone_col),
        .code      (mapped_code),
        .is_letter (is_letter)
    );

    assign qual = early_flag && !(inhibit_letters && is_letter);

    dtmf_guard_timer #(.PRESCALE(CLKS_PER_TICK), .LIMIT(PRESENT_TICKS)) u_present (
        .clk (clk), .rst_n (rst_n), .run (run_present), .expire (present_exp)
    );

    dtmf_guard_timer #(.PRESCALE(1), .LIMIT(SETTLE_CYCLES)) u_settle (
        .clk (clk), .rst_n (rst_n), .run (run_settle), .expire (settle_exp)
    );

    dtmf_guard_timer #(.PRESCALE(CLKS_PER_TICK), .LIMIT(ABSENT_TICKS)) u_absent (
        .clk (clk), .rst_n (rst_n), .run (run_absent), .expire (absent_exp)
    );

    dtmf_steer_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .qual        (qual),
        .present_exp (present_exp),
        .settle_exp  (settle_exp),
        .absent_exp  (absent_exp),
        .state       (state_q),
        .run_present (run_present),
        .run_settle  (run_settle),
        .run_absent  (run_absent),
        .load_code   (load_code),
        .delayed     (steer_delayed)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         latch_q <= '0;
        else if (load_code) latch_q <= mapped_code;
    end

    assign digit_q     = out_enable ? latch_q : 4'b0000;
    assign digit_drive = out_enable;

    // R3
    latch_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(latch_q) |-> (state_q == ST_SETTLE));

    // R3
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(steer_delayed) |-> ($past(state_q) == ST_SETTLE));

    // R5
    held_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (steer_delayed && $past(steer_delayed)) |-> $stable(latch_q));

    // R4
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(steer_delayed) |-> !$past(qual));

    // R2
    register_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && $past(state_q) != ST_SETTLE) |-> $past(early_flag));

    // R7
    inhibit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && $past(state_q) != ST_SETTLE)
            |-> !($past(inhibit_letters) && $past(is_letter)));

endmodule

// File: tb/tb_dtmf_steer_ctrl.sv
`timescale 1ns/1ps
module tb_dtmf_steer_ctrl;

    localparam int CPT = 3;
    localparam int PT  = 4;
    localparam int AT  = 3;
    localparam int SC  = 5;
    localparam int LP  = PT * CPT;
    localparam int LA  = AT * CPT;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       early = 1'b0;
    logic [1:0] row = 2'd0;
    logic [1:0] col = 2'd0;
    logic       inh = 1'b0;
    logic       oe = 1'b1;
    logic [3:0] digit_q;
    logic       digit_drive;
    logic       steer_delayed;

    int    vectors = 0;
    int    miscompares = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // behavioural reference
    int         mode = 0;
    int         hi_run = 0;
    int         lo_run = 0;
    int         settle_n = 0;
    logic [3:0] m_latch = 4'b0000;
    logic       m_flag = 1'b0;

    always #2.5 clk = ~clk;

    dtmf_steer_ctrl #(
        .CLKS_PER_TICK (CPT),
        .PRESENT_TICKS (PT),
        .ABSENT_TICKS  (AT),
        .SETTLE_CYCLES (SC)
    ) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .early_flag      (early),
        .tone_row        (row),
        .tone_col        (col),
        .inhibit_letters (inh),
        .out_enable      (oe),
        .digit_q         (digit_q),
        .digit_drive     (digit_drive),
        .steer_delayed   (steer_delayed)
    );

    function automatic logic [3:0] key_code(input logic [1:0] r, input logic [1:0] c);
        case ({r, c})
            4'h0: return 4'b0001;  4'h1: return 4'b0010;
            4'h2: return 4'b0011;  4'h3: return 4'b1101;
            4'h4: return 4'b0100;  4'h5: return 4'b0101;
            4'h6: return 4'b0110;  4'h7: return 4'b1110;
            4'h8: return 4'b0111;  4'h9: return 4'b1000;
            4'hA: return 4'b1001;  4'hB: return 4'b1111;
            4'hC: return 4'b1011;  4'hD: return 4'b1010;
            4'hE: return 4'b1100;  default: return 4'b0000;
        endcase
    endfunction

    always @(posedge clk) begin
        logic q;
        if (!rst_n) begin
            mode = 0; hi_run = 0; lo_run = 0; settle_n = 0;
            m_latch = 4'b0000; m_flag = 1'b0;
        end else begin
            q = early && !(inh && col == 2'd3);
            if (mode == 0) begin
                if (q) begin
                    hi_run++;
                    if (hi_run == LP) begin
                        m_latch = key_code(row, col);
                        mode = 1; settle_n = 0; hi_run = 0;
                    end
                end else hi_run = 0;
            end else if (mode == 1) begin
                settle_n++;
                if (settle_n == SC) begin mode = 2; m_flag = 1'b1; lo_run = 0; end
            end else begin
                if (!q) begin
                    lo_run++;
                    if (lo_run == LA) begin mode = 0; m_flag = 1'b0; hi_run = 0; end
                end else lo_run = 0;
            end
        end
    end

    always @(negedge clk) begin
        logic [3:0] exp_q;
        if (rst_n && !done) begin
            exp_q = oe ? m_latch : 4'b0000;
            vectors++;
            if (digit_q !== exp_q || digit_drive !== oe || steer_delayed !== m_flag) begin
                miscompares++;
                $display("FAIL %s digit_q=%b exp %b drive=%b exp %b steer=%b exp %b",
                         cur_req, digit_q, exp_q, digit_drive, oe, steer_delayed, m_flag);
            end
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic tone(input logic [1:0] r, input logic [1:0] c, input int n);
        early = 1'b1; row = r; col = c;
        wait_cycles(n);
    endtask

    task automatic quiet(input int n);
        early = 1'b0;
        wait_cycles(n);
    endtask

    task automatic check_eq(input logic [3:0] act, input logic [3:0] exp, input string req);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s direct check actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        miscompares++;
        $display("FAIL watchdog expired in %s", cur_req);
        finish_run();
    end

    initial begin
        // R1: reset state
        wait_cycles(3);
        check_eq(digit_q, 4'b0000, "R1");
        check_eq({3'b000, steer_delayed}, 4'b0000, "R1");
        rst_n = 1'b1;
        wait_cycles(2);
        check_eq(digit_q, 4'b0000, "R1");

        // R2: burst one short of the guard, then a full tone
        cur_req = "R2";
        tone(2'd1, 2'd1, LP - 1);
        quiet(4);
        check_eq(digit_q, 4'b0000, "R2");
        tone(2'd1, 2'd1, LP + SC + 4);
        check_eq(digit_q, 4'b0101, "R2");

        // R4: dropout one short, then exactly LA, then an immediate new tone
        cur_req = "R4";
        quiet(LA - 1);
        tone(2'd1, 2'd1, 6);
        check_eq({3'b000, steer_delayed}, 4'b0001, "R4");
        quiet(LA);
        tone(2'd0, 2'd2, LP + SC + 3);
        check_eq(digit_q, 4'b0011, "R4");

        // R5: code changes while the flag is high
        cur_req = "R5";
        row = 2'd2; col = 2'd0;
        wait_cycles(3 * LP);
        check_eq(digit_q, 4'b0011, "R5");
        quiet(LA + 2);

        // R3: settle interval observed every cycle by the model
        cur_req = "R3";
        tone(2'd2, 2'd0, LP + 2);
        wait_cycles(SC + 2);
        quiet(LA + 2);

        // R6: all sixteen pairs
        cur_req = "R6";
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 4; c++) begin
                tone(2'(r), 2'(c), LP + SC + 3);
                check_eq(digit_q, key_code(2'(r), 2'(c)), "R6");
                quiet(LA + 3);
            end
        end

        // R7: letters under inhibit
        cur_req = "R7";
        tone(2'd0, 2'd2, LP + SC + 3);
        quiet(LA + 2);
        inh = 1'b1;
        tone(2'd0, 2'd3, 3 * LP);
        check_eq(digit_q, 4'b0011, "R7");
        tone(2'd3, 2'd3, 3 * LP);
        check_eq(digit_q, 4'b0011, "R7");
        quiet(2);
        tone(2'd1, 2'd2, LP + SC + 3);
        check_eq(digit_q, 4'b0110, "R7");
        quiet(LA + 2);
        inh = 1'b0;
        tone(2'd3, 2'd3, LP + SC + 3);
        check_eq(digit_q, 4'b0000, "R7");
        quiet(LA + 2);

        // R8: output gating around a registration edge
        cur_req = "R8";
        tone(2'd2, 2'd2, LP - 1);
        oe = 1'b0;
        wait_cycles(2);
        check_eq(digit_q, 4'b0000, "R8");
        wait_cycles(SC + 2);
        oe = 1'b1;
        #0.5;
        check_eq(digit_q, 4'b1001, "R8");
        wait_cycles(2);
        oe = 1'b0;
        quiet(LA + 2);
        oe = 1'b1;
        #0.5;
        check_eq(digit_q, 4'b1001, "R8");
        wait_cycles(3);

        finish_run();
    end

endmodule